// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a memory-mapped slave holding the small control registers of a workstation I/O chip. It has seven registers: an 8-bit configuration register, 8-bit diagnostic and modem-control scratch registers, two 8-bit auxiliary registers, a 16-bit LED register and a 32-bit system-control register. Each register has its own select line on a simple bus that carries one write strobe, one read strobe, a 2-bit offset and 32-bit data. Read data is registered: it appears on `rdata_o` the cycle after the read strobe and holds until the next read.

Writes to the registers can have side effects. A bit in the first auxiliary register produces a terminal-count pulse and is never stored. A write to the second auxiliary register can request power-off or clear a power-fail flag. That flag is set by edges of an external power-failing line, and together with an enable bit in the configuration register it drives a level interrupt. A write with bit 0 set to the system-control register requests a system reset and records a reset-status value.

The block reset clears only part of the state. The diagnostic, LED and system-control registers keep their contents through it, so software can inspect them after a reset it requested itself.

Top module: `aux_sysctl_regs`

## Requirements
- R1: An active-low reset clears the configuration, modem-control and both auxiliary registers to 0 and drives all pulse and interrupt outputs low. The diagnostic, LED and system-control registers keep their values through the reset.
- R2: The configuration, diagnostic and modem-control registers are plain 8-bit read/write storage. A read returns the stored byte on `rdata_o[7:0]` with bits 31:8 zero, in the cycle after `re_i`.
- R3: A write to aux1 with data bit 1 set gives a one-cycle high pulse on `tc_pulse_o` in the cycle after the write. Aux1 stores bit 1 as 0 and all other bits as written.
- R4: A write to aux2 takes only data bits 0 and 1. Stored bits 7:6 and 4:2 are always 0, and stored bit 5 (power-fail flag) keeps its value.
- R5: A write to aux2 with data bit 1 set leaves only data bit 0 stored, which clears the power-fail flag.
- R6: A write to aux2 with data bit 0 set gives a one-cycle `pwroff_req_o` pulse in the cycle after the write.
- R7: When `pwr_failing_i` changes and the new level is 1 while configuration bit 3 is set, aux2 bit 5 is set. Any other change of the input clears it. While the input does not change, the flag is left alone. An input change in the same cycle as an aux2 write decides bit 5.
- R8: `irq_o` is high exactly when aux2 bit 5 and configuration bit 3 are both set. It follows a configuration write, an aux2 write or an input change one cycle later.
- R9: A write to system control at offset 0 with data bit 0 set loads the value 0x00000002 and gives a one-cycle `sysrst_req_o` pulse. A write with bit 0 clear leaves the register unchanged.
- R10: The LED register (16 bits) and the system-control register respond only at offset 0. At any other offset, reads return 0 and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 7 | One select per register: 0 cfg, 1 diag, 2 modem, 3 aux1, 4 aux2, 5 LED, 6 system control |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | 2 | Offset within the selected register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pwr_failing_i | input | 1 | External power-failing status |
| irq_o | output | 1 | Level power-fail interrupt |
| tc_pulse_o | output | 1 | Terminal-count pulse |
| pwroff_req_o | output | 1 | Power-off request pulse |
| sysrst_req_o | output | 1 | System-reset request pulse |

## Verification
The assertions check these on every cycle:
- the interrupt level always matches the stored flag and the enable bit;
- the unused aux2 bits stay zero, and aux1 bit 1 is never stored;
- the power-fail flag only moves on an input edge or an aux2 write;
- every reset-request pulse coincides with the reset-status value.

Only the bench scenarios can show the rest:
- which values survive a block reset and which are cleared;
- the offset filtering of the LED and system-control windows;
- the one-cycle read latency;
- that re-enabling the interrupt while the input stays high does not set the flag.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;
  localparam int NUM_SEL  = 7;
  localparam int SEL_CFG  = 0;
  localparam int SEL_DIAG = 1;
  localparam int SEL_MDM  = 2;
  localparam int SEL_AUX1 = 3;
  localparam int SEL_AUX2 = 4;
  localparam int SEL_LED  = 5;
  localparam int SEL_SYS  = 6;

  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_RST_BIT  = 0;
  localparam int SYS_STAT_BIT = 1;
endpackage

// File: rtl/aux_plain_reg.sv
module aux_plain_reg #(
  parameter int          W       = 8,
  parameter bit          HAS_RST = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= RST_VAL;
        else if (we_i) q <= d_i;
      end
    end else begin : g_keep
      // survives reset; writes blocked while reset is held
      always_ff @(posedge clk_i) begin
        if (we_i && rst_ni) q <= d_i;
      end
    end
  endgenerate

  assign q_o = q;
endmodule

// File: rtl/aux_pwr_ctl.sv
module aux_pwr_ctl import aux_ctl_pkg::*; #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          aux2_we_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          pf_i,
  output logic [BW-1:0] cfg_o,
  output logic [BW-1:0] aux2_o,
  output logic          irq_o,
  output logic          pwroff_o
);
  logic [BW-1:0] cfg_q, cfg_d, aux2_q, aux2_d;
  logic          pf_q, pf_chg, irq_q, off_q;

  assign pf_chg = pf_i ^ pf_q;

  always_comb begin
    cfg_d  = cfg_we_i ? wdata_i : cfg_q;
    aux2_d = aux2_q;
    if (aux2_we_i) begin
      aux2_d               = '0;
      aux2_d[AUX2_OFF_BIT] = wdata_i[AUX2_OFF_BIT];
      aux2_d[AUX2_CLR_BIT] = wdata_i[AUX2_CLR_BIT];
      aux2_d[AUX2_PF_BIT]  = aux2_q[AUX2_PF_BIT];
      if (wdata_i[AUX2_CLR_BIT]) begin
        aux2_d[AUX2_CLR_BIT] = 1'b0;
        aux2_d[AUX2_PF_BIT]  = 1'b0;
      end
    end
    // input edge wins over a same-cycle write
    if (pf_chg) aux2_d[AUX2_PF_BIT] = pf_i & cfg_q[CFG_PIE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      aux2_q <= '0;
      pf_q   <= 1'b0;
      irq_q  <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      aux2_q <= aux2_d;
      pf_q   <= pf_i;
      irq_q  <= aux2_d[AUX2_PF_BIT] & cfg_d[CFG_PIE_BIT];
      off_q  <= aux2_we_i & wdata_i[AUX2_OFF_BIT];
    end
  end

  assign cfg_o    = cfg_q;
  assign aux2_o   = aux2_q;
  assign irq_o    = irq_q;
  assign pwroff_o = off_q;

  a_r8_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == (aux2_q[AUX2_PF_BIT] && cfg_q[CFG_PIE_BIT]));
  a_r4_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux2_q & ~((BW'(1) << AUX2_PF_BIT) | (BW'(1) << AUX2_OFF_BIT))) == '0);
  a_r5_clear_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux2_we_i && wdata_i[AUX2_CLR_BIT] && !pf_chg) |=> !aux2_q[AUX2_PF_BIT]);
  a_r7_hold_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pf_chg && !aux2_we_i) |=> (aux2_q[AUX2_PF_BIT] == $past(aux2_q[AUX2_PF_BIT])));
  a_r7_set_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_chg && pf_i && cfg_q[CFG_PIE_BIT]) |=> aux2_q[AUX2_PF_BIT]);
  a_r6_off_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> aux2_q[AUX2_OFF_BIT]);
endmodule

// File: rtl/aux_sys_ctl.sv
module aux_sys_ctl import aux_ctl_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o,
  output logic          rst_req_o
);
  localparam logic [DW-1:0] STAT_VAL = DW'(1) << SYS_STAT_BIT;

  logic [DW-1:0] sys_q;
  logic          req_q;
  logic          hit;

  assign hit = we_i & wdata_i[SYS_RST_BIT];

  // status survives block reset
  always_ff @(posedge clk_i) begin
    if (hit && rst_ni) sys_q <= STAT_VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= hit;
  end

  assign q_o       = sys_q;
  assign rst_req_o = req_q;

  a_r9_stat_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> (sys_q == STAT_VAL));
  a_r9_keep_no_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[SYS_RST_BIT]) |=> $stable(sys_q));
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs import aux_ctl_pkg::*; #(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SEL-1:0] sel_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               pwr_failing_i,
  output logic               irq_o,
  output logic               tc_pulse_o,
  output logic               pwroff_req_o,
  output logic               sysrst_req_o
);
  localparam int BW = 8;
  localparam int LW = 16;

  logic [NUM_SEL-1:0] wr;
  logic               off_zero;
  logic [BW-1:0]      cfg_q, diag_q, mdm_q, aux1_q, aux2_q;
  logic [LW-1:0]      led_q;
  logic [DW-1:0]      sys_q, rd_d, rd_q;
  logic               tc_q;

  assign wr       = sel_i & {NUM_SEL{we_i}};
  assign off_zero = (addr_i == '0);

  aux_plain_reg #(.W(BW), .HAS_RST(1'b0)) u_diag (
    .clk_i, .rst_ni, .we_i(wr[SEL_DIAG]), .d_i(wdata_i[BW-1:0]), .q_o(diag_q));

  aux_plain_reg #(.W(BW), .HAS_RST(1'b1)) u_mdm (
    .clk_i, .rst_ni, .we_i(wr[SEL_MDM]), .d_i(wdata_i[BW-1:0]), .q_o(mdm_q));

  aux_plain_reg #(.W(BW), .HAS_RST(1'b1)) u_aux1 (
    .clk_i, .rst_ni, .we_i(wr[SEL_AUX1]),
    .d_i(wdata_i[BW-1:0] & ~(BW'(1) << AUX1_TC_BIT)), .q_o(aux1_q));

  aux_plain_reg #(.W(LW), .HAS_RST(1'b0)) u_led (
    .clk_i, .rst_ni, .we_i(wr[SEL_LED] & off_zero), .d_i(wdata_i[LW-1:0]), .q_o(led_q));

  aux_pwr_ctl #(.BW(BW)) u_pwr (
    .clk_i, .rst_ni,
    .cfg_we_i(wr[SEL_CFG]), .aux2_we_i(wr[SEL_AUX2]), .wdata_i(wdata_i[BW-1:0]),
    .pf_i(pwr_failing_i), .cfg_o(cfg_q), .aux2_o(aux2_q),
    .irq_o(irq_o), .pwroff_o(pwroff_req_o));

  aux_sys_ctl #(.DW(DW)) u_sys (
    .clk_i, .rst_ni, .we_i(wr[SEL_SYS] & off_zero), .wdata_i(wdata_i),
    .q_o(sys_q), .rst_req_o(sysrst_req_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tc_q <= 1'b0;
    else         tc_q <= wr[SEL_AUX1] & wdata_i[AUX1_TC_BIT];
  end
  assign tc_pulse_o = tc_q;

  always_comb begin
    rd_d = '0;
    if (sel_i[SEL_CFG])              rd_d |= DW'(cfg_q);
    if (sel_i[SEL_DIAG])             rd_d |= DW'(diag_q);
    if (sel_i[SEL_MDM])              rd_d |= DW'(mdm_q);
    if (sel_i[SEL_AUX1])             rd_d |= DW'(aux1_q);
    if (sel_i[SEL_AUX2])             rd_d |= DW'(aux2_q);
    if (sel_i[SEL_LED] && off_zero)  rd_d |= DW'(led_q);
    if (sel_i[SEL_SYS] && off_zero)  rd_d |= sys_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= rd_d;
  end
  assign rdata_o = rd_q;

  a_r3_tc_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux1_q[AUX1_TC_BIT]);
  a_r3_tc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |=> (!tc_q || $past(wr[SEL_AUX1] && wdata_i[AUX1_TC_BIT])));
endmodule

// File: tb/tb_aux_sysctl_regs.sv
`timescale 1ns/1ps
module tb_aux_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  sel_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pf = 1'b0;
  logic        irq_o, tc_pulse_o, pwroff_req_o, sysrst_req_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic tc_seen, off_seen, rst_seen;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  aux_sysctl_regs dut (
    .clk_i(clk), .rst_ni, .sel_i, .we_i, .re_i, .addr_i, .wdata_i, .rdata_o,
    .pwr_failing_i(pf), .irq_o, .tc_pulse_o, .pwroff_req_o, .sysrst_req_o);

  localparam int CFG = 0, DIAG = 1, MDM = 2, AUX1 = 3, AUX2 = 4, LED = 5, SYS = 6;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sel;
    logic [1:0]  off;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'(DIAG), 2'd0, 32'h000000A5, 32'h0,        4'd2},
    '{1'b0, 3'(DIAG), 2'd0, 32'h0,        32'h000000A5, 4'd2},   // R2
    '{1'b1, 3'(MDM),  2'd0, 32'hFFFFFF3C, 32'h0,        4'd2},
    '{1'b0, 3'(MDM),  2'd0, 32'h0,        32'h0000003C, 4'd2},   // R2 upper bits zero
    '{1'b1, 3'(CFG),  2'd0, 32'h000000F7, 32'h0,        4'd2},
    '{1'b0, 3'(CFG),  2'd0, 32'h0,        32'h000000F7, 4'd2},   // R2
    '{1'b1, 3'(AUX1), 2'd0, 32'h000000FF, 32'h0,        4'd3},
    '{1'b0, 3'(AUX1), 2'd0, 32'h0,        32'h000000FD, 4'd3},   // R3 bit1 dropped
    '{1'b1, 3'(AUX2), 2'd0, 32'h000000FF, 32'h0,        4'd5},
    '{1'b0, 3'(AUX2), 2'd0, 32'h0,        32'h00000001, 4'd5},   // R5
    '{1'b1, 3'(AUX2), 2'd0, 32'h000000FC, 32'h0,        4'd4},
    '{1'b0, 3'(AUX2), 2'd0, 32'h0,        32'h00000000, 4'd4},   // R4
    '{1'b1, 3'(LED),  2'd0, 32'h0000BEEF, 32'h0,        4'd10},
    '{1'b0, 3'(LED),  2'd0, 32'h0,        32'h0000BEEF, 4'd10},  // R10
    '{1'b1, 3'(LED),  2'd2, 32'h00001234, 32'h0,        4'd10},
    '{1'b0, 3'(LED),  2'd0, 32'h0,        32'h0000BEEF, 4'd10},
    '{1'b0, 3'(LED),  2'd2, 32'h0,        32'h00000000, 4'd10},
    '{1'b1, 3'(SYS),  2'd0, 32'h00000001, 32'h0,        4'd9},
    '{1'b0, 3'(SYS),  2'd0, 32'h0,        32'h00000002, 4'd9},   // R9
    '{1'b1, 3'(SYS),  2'd0, 32'hFFFFFFFE, 32'h0,        4'd9},
    '{1'b0, 3'(SYS),  2'd0, 32'h0,        32'h00000002, 4'd9},
    '{1'b0, 3'(SYS),  2'd1, 32'h0,        32'h00000000, 4'd10},
    '{1'b1, 3'(SYS),  2'd3, 32'h00000000, 32'h0,        4'd10},
    '{1'b0, 3'(SYS),  2'd0, 32'h0,        32'h00000002, 4'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int s, input logic [1:0] off, input logic [31:0] d);
    @(negedge clk);
    sel_i = 7'(1 << s); addr_i = off; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    sel_i = '0; we_i = 1'b0; wdata_i = '0; addr_i = '0;
    tc_seen = tc_pulse_o; off_seen = pwroff_req_o; rst_seen = sysrst_req_o;
  endtask

  task automatic bus_read(input int s, input logic [1:0] off, output logic [31:0] d);
    @(negedge clk);
    sel_i = 7'(1 << s); addr_i = off; re_i = 1'b1;
    @(negedge clk);
    sel_i = '0; re_i = 1'b0; addr_i = '0;
    d = rdata_o;
  endtask

  task automatic pulses_low(input string req);
    @(negedge clk);
    check(req, {29'd0, tc_pulse_o, pwroff_req_o, sysrst_req_o}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {28'd0, irq_o, tc_pulse_o, pwroff_req_o, sysrst_req_o}, 32'h0);
    check("R1 rdata", rdata_o, 32'h0);
    bus_read(CFG, 0, rd);  check("R1 cfg", rd, 32'h0);
    bus_read(AUX1, 0, rd); check("R1 aux1", rd, 32'h0);
    bus_read(AUX2, 0, rd); check("R1 aux2", rd, 32'h0);
    bus_read(MDM, 0, rd);  check("R1 mdm", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(int'(VEC[i].sel), VEC[i].off, VEC[i].data);
      else begin
        bus_read(int'(VEC[i].sel), VEC[i].off, rd);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end

    // R2 read latency: data holds until next strobe
    @(negedge clk); check("R2 hold", rdata_o, 32'h2);

    // R3 terminal-count pulse
    bus_write(AUX1, 0, 32'h02);
    check("R3 pulse", {31'd0, tc_seen}, 32'h1);
    pulses_low("R3 single");
    bus_read(AUX1, 0, rd); check("R3 stored", rd, 32'h0);
    bus_write(AUX1, 0, 32'h81);
    check("R3 no pulse", {31'd0, tc_seen}, 32'h0);

    // R6 power-off request
    bus_write(AUX2, 0, 32'h01);
    check("R6 pulse", {31'd0, off_seen}, 32'h1);
    pulses_low("R6 single");
    bus_write(AUX2, 0, 32'h00);
    check("R6 no pulse", {31'd0, off_seen}, 32'h0);

    // R7 / R8 power fail
    bus_write(CFG, 0, 32'h08);
    @(negedge clk); pf = 1'b1;
    @(negedge clk); check("R8 irq on edge", {31'd0, irq_o}, 32'h1);
    bus_read(AUX2, 0, rd); check("R7 flag set", rd, 32'h20);
    bus_write(AUX2, 0, 32'h00);
    bus_read(AUX2, 0, rd); check("R4 flag kept", rd, 32'h20);
    check("R8 irq kept", {31'd0, irq_o}, 32'h1);
    bus_write(AUX2, 0, 32'h02);
    check("R8 irq cleared", {31'd0, irq_o}, 32'h0);
    bus_read(AUX2, 0, rd); check("R5 clear", rd, 32'h0);
    @(negedge clk); pf = 1'b0;
    bus_write(CFG, 0, 32'h00);
    @(negedge clk); pf = 1'b1;
    @(negedge clk);
    bus_read(AUX2, 0, rd); check("R7 disabled edge", rd, 32'h0);
    bus_write(CFG, 0, 32'h08);
    bus_read(AUX2, 0, rd); check("R7 no edge no set", rd, 32'h0);
    check("R8 no irq", {31'd0, irq_o}, 32'h0);
    @(negedge clk); pf = 1'b0;
    @(negedge clk); pf = 1'b1;
    @(negedge clk); check("R8 irq again", {31'd0, irq_o}, 32'h1);
    bus_write(CFG, 0, 32'h00);
    check("R8 cfg masks", {31'd0, irq_o}, 32'h0);
    bus_read(AUX2, 0, rd); check("R7 flag survives cfg", rd, 32'h20);
    bus_write(CFG, 0, 32'h08);
    check("R8 cfg unmasks", {31'd0, irq_o}, 32'h1);
    @(negedge clk); pf = 1'b0;
    @(negedge clk); check("R7 falling edge clears", {31'd0, irq_o}, 32'h0);

    // R9 reset request
    bus_write(SYS, 0, 32'h00000001);
    check("R9 pulse", {31'd0, rst_seen}, 32'h1);
    pulses_low("R9 single");
    bus_write(SYS, 0, 32'h00000000);
    check("R9 no pulse", {31'd0, rst_seen}, 32'h0);
    bus_write(SYS, 2, 32'h00000001);
    check("R10 offset no pulse", {31'd0, rst_seen}, 32'h0);

    // R1 selective reset
    bus_write(DIAG, 0, 32'h5A);
    bus_write(LED, 0, 32'h1357);
    bus_write(MDM, 0, 32'h77);
    bus_write(AUX1, 0, 32'h40);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); check("R1 irq in reset", {31'd0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    bus_read(DIAG, 0, rd); check("R1 diag kept", rd, 32'h5A);
    bus_read(LED, 0, rd);  check("R1 led kept", rd, 32'h1357);
    bus_read(SYS, 0, rd);  check("R1 sys kept", rd, 32'h2);
    bus_read(MDM, 0, rd);  check("R1 mdm cleared", rd, 32'h0);
    bus_read(CFG, 0, rd);  check("R1 cfg cleared", rd, 32'h0);
    bus_read(AUX1, 0, rd); check("R1 aux1 cleared", rd, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule